// File: doc/BRIEF.md
# Walsh Sequence Regenerator and Demodulator

This block removes a per-tile Walsh switching pattern from a stream of signed ADC samples. The host loads a 16-bit pattern, one bit per Walsh state. The block keeps its own timebase. Each state lasts a fixed number of clock cycles, and sixteen states make one Walsh cycle. The sign for each incoming sample is taken from the pattern bit of the state that is current when the sample arrives.

The timebase runs freely, but it is pulled into line by a slow external sync pulse. Each rising edge of that pulse, once it has passed through a synchronizer, restarts the cycle at state 0. The block raises a one-cycle strobe on every cycle boundary, whether the boundary comes from the internal wrap or from a sync restart. At each boundary the state generator reloads from the pattern register, so a newly written pattern takes effect only at a boundary.

A sync edge should fall exactly where the timebase would have wrapped anyway. When it falls anywhere else, the internal sequence has slipped, and a sticky flag records this until the host clears it.

Top module: `walsh_demod`

## Requirements
- R1: While reset is high and on the first cycle after it, all outputs are zero: demodulated data, data valid, state index, cycle strobe and slip flag.
- R2: The state index counts 0 to 15. It advances after every STATE_LEN clock cycles. After state 15 it wraps to 0, and `cycle_strobe_o` is high for exactly the first clock of state 0.
- R3: Bit k of the active pattern sets the sign for samples that arrive during state k. A 1 gives the two's-complement negation of the sample and a 0 gives the sample unchanged. The result is sign-extended to SAMPLE_W+1 bits and appears one clock after the sample, with `demod_valid_o` high.
- R4: Negating the most negative input (-2^(SAMPLE_W-1)) gives +2^(SAMPLE_W-1) without overflow.
- R5: Suppose `sync_i` is first sampled high at clock edge t after being low. Then edge t+SYNC_STAGES restarts the cycle: the next clock shows state 0 with the strobe high. Holding `sync_i` high does not restart the cycle again.
- R6: A pattern written with `pat_wr_i` does not change any sign until the next cycle boundary, whether that boundary is a natural wrap or a sync restart. From that boundary on, the new pattern is the active one. The active pattern is all zeros after reset.
- R7: The first sync restart after reset never sets the slip flag. Any later restart sets it, unless the restart lands on the same edge as the natural wrap from state 15 to state 0.
- R8: The slip flag stays set until a `slip_clr_i` pulse clears it. If a slip and a clear happen on the same edge, the slip wins.
- R9: A cycle with `sample_valid_i` low drives `demod_valid_o` low on the next clock and leaves `demod_o` holding its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | SAMPLE_W | Signed ADC sample |
| sample_valid_i | input | 1 | Sample qualifier |
| sync_i | input | 1 | Slow external sync, asynchronous |
| pat_wr_i | input | 1 | Host write strobe for the pattern |
| pat_i | input | NUM_STATES | Pattern value, bit k gives the sign of state k |
| slip_clr_i | input | 1 | Host clear pulse for the slip flag |
| demod_o | output | SAMPLE_W+1 | Demodulated signed sample |
| demod_valid_o | output | 1 | Qualifier for `demod_o` |
| state_idx_o | output | log2(NUM_STATES) | Current Walsh state |
| cycle_strobe_o | output | 1 | High on the first clock of each Walsh cycle |
| slip_o | output | 1 | Sticky slip flag |

## Verification
The hardest case to produce is a sync edge that lands exactly on the natural wrap, because only that edge leaves the slip flag clear. The bench's own model tracks the state and the count within the state. It raises `sync_i` when the model sits SYNC_STAGES clocks before the end of state 15, so the synchronized edge reaches the wrap edge itself. The same model then places deliberately misaligned sync edges, checks that the flag holds and clears, and issues pattern writes in the middle of a cycle so that the old and new signs can be told apart on each side of the boundary.

// File: rtl/wd_pkg.sv
package wd_pkg;
  // sign selection for one Walsh state
  typedef enum logic {
    SGN_PASS = 1'b0,
    SGN_NEG  = 1'b1
  } wd_sign_e;
endpackage

// File: rtl/wd_sync_edge.sv
module wd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= async_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // R5: a detected edge is a single-cycle event
  p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/wd_timebase.sv
module wd_timebase #(
  parameter int NUM_STATES = 16,
  parameter int STATE_LEN  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sync_evt_i,
  input  logic                          slip_clr_i,
  output logic                          boundary_o,
  output logic                          step_o,
  output logic [$clog2(NUM_STATES)-1:0] idx_o,
  output logic                          strobe_o,
  output logic                          slip_o
);
  localparam int IW = $clog2(NUM_STATES);
  localparam int CW = (STATE_LEN > 1) ? $clog2(STATE_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STATE_LEN - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NUM_STATES - 1);

  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic          strobe_q, slip_q, locked_q;
  logic          state_end, cycle_end;

  assign state_end  = (cnt_q == CNT_LAST);
  assign cycle_end  = state_end && (idx_q == IDX_LAST);
  assign boundary_o = sync_evt_i || cycle_end;
  assign step_o     = state_end && !boundary_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      idx_q    <= '0;
      strobe_q <= 1'b0;
    end else if (boundary_o) begin
      cnt_q    <= '0;
      idx_q    <= '0;
      strobe_q <= 1'b1;
    end else if (state_end) begin
      cnt_q    <= '0;
      idx_q    <= idx_q + IW'(1);
      strobe_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_q + CW'(1);
      strobe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slip_q   <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (sync_evt_i && locked_q && !cycle_end) slip_q <= 1'b1;
      else if (slip_clr_i)                      slip_q <= 1'b0;
      if (sync_evt_i) locked_q <= 1'b1;
    end
  end

  assign idx_o    = idx_q;
  assign strobe_o = strobe_q;
  assign slip_o   = slip_q;

  p_idx_bound_r2: assert property (@(posedge clk) disable iff (rst)
    idx_q <= IDX_LAST);
  p_strobe_pos_r2: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> (idx_q == '0 && cnt_q == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    step_o |=> (idx_q == $past(idx_q) + IW'(1)));
  p_resync_r5: assert property (@(posedge clk) disable iff (rst)
    sync_evt_i |=> (strobe_q && cnt_q == '0));
  p_slip_set_r7: assert property (@(posedge clk) disable iff (rst)
    (sync_evt_i && locked_q && !cycle_end) |=> slip_q);
  p_first_sync_r7: assert property (@(posedge clk) disable iff (rst)
    (!locked_q && !slip_q) |=> !slip_q);
  p_slip_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (slip_q && !slip_clr_i) |=> slip_q);
endmodule

// File: rtl/wd_pattern.sv
module wd_pattern
  import wd_pkg::*;
#(
  parameter int NUM_STATES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  logic [NUM_STATES-1:0] pat_i,
  input  logic                  boundary_i,
  input  logic                  step_i,
  output wd_sign_e              sign_o
);
  logic [NUM_STATES-1:0] pend_q;
  logic [NUM_STATES-1:0] run_q;

  // pending copy, written by the host at any time
  always_ff @(posedge clk) begin
    if (rst)       pend_q <= '0;
    else if (wr_i) pend_q <= pat_i;
  end

  // running copy: reloaded at each boundary, shifted once per state
  always_ff @(posedge clk) begin
    if (rst)             run_q <= '0;
    else if (boundary_i) run_q <= pend_q;
    else if (step_i)     run_q <= run_q >> 1;
  end

  assign sign_o = run_q[0] ? SGN_NEG : SGN_PASS;

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    boundary_i |=> (run_q == $past(pend_q)));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!boundary_i && !step_i) |=> $stable(run_q));
endmodule

// File: rtl/wd_negate.sv
module wd_negate
  import wd_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] din_i,
  input  logic                       dvalid_i,
  input  wd_sign_e                   sign_i,
  output logic signed [SAMPLE_W:0]   dout_o,
  output logic                       dvalid_o
);
  localparam int OW = SAMPLE_W + 1;
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [OW-1:0]       MOST_POS = {2'b01, {(SAMPLE_W-1){1'b0}}};

  logic signed [OW-1:0] ext, neg;
  logic signed [OW-1:0] dout_q;
  logic                 dvalid_q;

  assign ext = {din_i[SAMPLE_W-1], din_i};
  assign neg = -ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      dvalid_q <= 1'b0;
    end else begin
      dvalid_q <= dvalid_i;
      if (dvalid_i) dout_q <= (sign_i == SGN_NEG) ? neg : ext;
    end
  end

  assign dout_o   = dout_q;
  assign dvalid_o = dvalid_q;

  p_min_neg_r4: assert property (@(posedge clk) disable iff (rst)
    (dvalid_i && sign_i == SGN_NEG && din_i == MOST_NEG) |=> (dout_q == MOST_POS));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !dvalid_i |=> ($stable(dout_q) && !dvalid_q));
  p_valid_r3: assert property (@(posedge clk) disable iff (rst)
    dvalid_i |=> dvalid_q);
endmodule

// File: rtl/walsh_demod.sv
module walsh_demod
  import wd_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int NUM_STATES  = 16,
  parameter int STATE_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SAMPLE_W-1:0]           sample_i,
  input  logic                          sample_valid_i,
  input  logic                          sync_i,
  input  logic                          pat_wr_i,
  input  logic [NUM_STATES-1:0]         pat_i,
  input  logic                          slip_clr_i,
  output logic [SAMPLE_W:0]             demod_o,
  output logic                          demod_valid_o,
  output logic [$clog2(NUM_STATES)-1:0] state_idx_o,
  output logic                          cycle_strobe_o,
  output logic                          slip_o
);
  logic     sync_evt, boundary, step;
  wd_sign_e sign;
  logic signed [SAMPLE_W:0] dout;

  wd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(sync_i), .rise_o(sync_evt)
  );

  wd_timebase #(.NUM_STATES(NUM_STATES), .STATE_LEN(STATE_LEN)) u_tb (
    .clk(clk), .rst(rst), .sync_evt_i(sync_evt), .slip_clr_i(slip_clr_i),
    .boundary_o(boundary), .step_o(step), .idx_o(state_idx_o),
    .strobe_o(cycle_strobe_o), .slip_o(slip_o)
  );

  wd_pattern #(.NUM_STATES(NUM_STATES)) u_pat (
    .clk(clk), .rst(rst), .wr_i(pat_wr_i), .pat_i(pat_i),
    .boundary_i(boundary), .step_i(step), .sign_o(sign)
  );

  wd_negate #(.SAMPLE_W(SAMPLE_W)) u_neg (
    .clk(clk), .rst(rst), .din_i(sample_i), .dvalid_i(sample_valid_i),
    .sign_i(sign), .dout_o(dout), .dvalid_o(demod_valid_o)
  );

  assign demod_o = dout;
endmodule

// File: tb/sim_walsh_demod.sv
`timescale 1ns/1ps
module sim_walsh_demod;
  localparam int W = 8, N = 16, LEN = 4, STG = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] b_smp = '0;
  logic b_dv = 1'b0, b_sync = 1'b0, b_wr = 1'b0, b_clr = 1'b0;
  logic [N-1:0] b_pat = '0;
  logic [W:0] demod;
  logic dval, strb, slip;
  logic [3:0] sidx;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  walsh_demod #(.SAMPLE_W(W), .NUM_STATES(N), .STATE_LEN(LEN), .SYNC_STAGES(STG)) u0 (
    .clk(clk), .rst(rst), .sample_i(b_smp), .sample_valid_i(b_dv), .sync_i(b_sync),
    .pat_wr_i(b_wr), .pat_i(b_pat), .slip_clr_i(b_clr), .demod_o(demod),
    .demod_valid_o(dval), .state_idx_o(sidx), .cycle_strobe_o(strb), .slip_o(slip)
  );

  // behavioural reference model
  int m_cnt, m_idx, m_dout;
  bit m_dval, m_strb, m_slip, m_locked;
  int unsigned m_cur, m_pend;
  bit hist[0:STG];

  always @(posedge clk) begin
    bit evt, wrap, endc;
    if (rst) begin
      m_cnt = 0; m_idx = 0; m_dout = 0; m_dval = 0; m_strb = 0;
      m_slip = 0; m_locked = 0; m_cur = 0; m_pend = 0;
      for (int k = 0; k <= STG; k++) hist[k] = 0;
    end else begin
      evt  = hist[STG-1] && !hist[STG];
      wrap = (m_cnt == LEN-1);
      endc = wrap && (m_idx == N-1);
      if (b_dv) m_dout = ((m_cur >> m_idx) & 1) ? -int'($signed(b_smp)) : int'($signed(b_smp));
      m_dval = b_dv;
      if (evt && m_locked && !endc) m_slip = 1;
      else if (b_clr) m_slip = 0;
      if (evt) m_locked = 1;
      if (evt || endc) begin m_cnt = 0; m_idx = 0; m_strb = 1; m_cur = m_pend; end
      else if (wrap) begin m_cnt = 0; m_idx++; m_strb = 0; end
      else begin m_cnt++; m_strb = 0; end
      if (b_wr) m_pend = b_pat;
      for (int k = STG; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = b_sync;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R3 R4 demod_o", int'($signed(demod)), m_dout);
      chk("R9 demod_valid_o", int'(dval), int'(m_dval));
      chk("R2 state_idx_o", int'(sidx), m_idx);
      chk("R2 R5 cycle_strobe_o", int'(strb), int'(m_strb));
      chk("R7 R8 slip_o", int'(slip), int'(m_slip));
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      b_smp = W'($urandom);
      if ($urandom % 8 == 0) b_smp = {1'b1, {(W-1){1'b0}}};
      b_dv = ($urandom % 4) != 0;
      b_wr = 0; b_clr = 0;
    end
  endtask

  task automatic pulse_sync();
    @(negedge clk); b_sync = 1;
    tick(3);
    @(negedge clk); b_sync = 0;
  endtask

  task automatic wait_model(input int idx, input int cnt);
    do @(negedge clk); while (!(m_idx == idx && m_cnt == cnt));
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs are zero during reset
    chk("R1 reset demod", int'(demod), 0);
    chk("R1 reset strobe", int'(strb), 0);
    chk("R1 reset slip", int'(slip), 0);
    @(negedge clk); rst = 0;
    tick(150);
    @(negedge clk); b_wr = 1; b_pat = 16'hA5C3;
    tick(200);
    // R7: first sync never sets slip
    pulse_sync();
    tick(10);
    chk("R7 first sync", int'(slip), 0);
    // R7: sync aligned with natural wrap
    wait_model(N-1, LEN-1-STG);
    b_sync = 1; tick(3); @(negedge clk); b_sync = 0;
    tick(10);
    chk("R7 aligned sync", int'(slip), 0);
    // R7: misaligned sync sets slip
    wait_model(5, 0);
    pulse_sync();
    tick(4);
    chk("R7 misaligned sync", int'(slip), 1);
    // R8: sticky, then cleared
    tick(100);
    chk("R8 sticky", int'(slip), 1);
    @(negedge clk); b_clr = 1;
    @(negedge clk); b_clr = 0;
    chk("R8 cleared", int'(slip), 0);
    // R6 / R4 directed: clear pattern, then write all ones mid cycle
    @(negedge clk); b_wr = 1; b_pat = '0;
    do tick(1); while (!strb);
    wait_model(3, 0);
    b_wr = 1; b_pat = '1; b_smp = 8'd5; b_dv = 1;
    @(negedge clk); b_wr = 0;
    chk("R6 old pattern still active", int'($signed(demod)), 5);
    do tick(1); while (!strb);
    b_smp = 8'd5; b_dv = 1;
    @(negedge clk);
    chk("R6 new pattern at boundary", int'($signed(demod)), -5);
    b_smp = 8'h80; b_dv = 1;
    @(negedge clk);
    chk("R4 most negative", int'($signed(demod)), 128);
    b_dv = 0;
    @(negedge clk);
    chk("R9 hold", int'($signed(demod)), 128);
    // mixed random traffic
    for (int r = 0; r < 12; r++) begin
      tick(60 + ($urandom % 80));
      @(negedge clk); b_wr = 1; b_pat = N'($urandom);
      tick(40);
      if (r % 3 == 0) begin
        wait_model(N-1, LEN-1-STG);
        b_sync = 1; tick(3); @(negedge clk); b_sync = 0;
      end else if (r % 3 == 1) begin
        pulse_sync();
      end else begin
        @(negedge clk); b_clr = 1;
      end
    end
    tick(100);
    finish_run();
  end
endmodule